// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits beside the pipeline of a small 32-bit RISC core and turns trap events into control-flow changes. Upstream logic reports four kinds of event as single-cycle strobes: a breakpoint, a data bus error (raised for both unmapped and misaligned accesses), an unsigned divide or modulo with a zero divisor, and a system call. The current instruction address comes with them. For the one event it accepts, the block produces three results. It gives a redirect target formed from a base register plus the event number times 32. It gives a register-file write that saves the faulting address into a link register. It also updates its three-bit interrupt-enable state.

A return branch also passes through the block. When the branch source register is one of the two link registers, the saved enable bit is moved back into bit 0. Any other source register leaves the enable state as it is. In every case the branch goes to the value supplied with it. The block also holds the exception base, the debug base and an interrupt-pending register. The pending register collects interrupt requests, and a control-register write clears any bit written as 1. All results are registered and appear one cycle after the stimulus that causes them.

Top module: `exc_ctrl`

## Requirements
- R1: After reset the enable state, both base registers and the pending register read zero, and the redirect and register-write outputs are low.
- R2: A data bus error, divide-by-zero or system-call strobe produces, one cycle later, a redirect to the exception base plus 32 times its number (data bus error 4, divide-by-zero 5, system call 7). In the same cycle it produces a register write of the faulting address to register 30.
- R3: On an R2 event the enable state becomes old bit 0 moved to bit 1, with bits 0 and 2 cleared.
- R4: A breakpoint strobe (number 1) produces, one cycle later, a redirect to the debug base plus 32 and a write of the address to register 31. The enable state becomes old bit 0 moved to bit 2, with the other bits cleared.
- R5: When several strobes are active in one cycle, only one is taken, in the order breakpoint, data bus error, divide-by-zero, system call.
- R6: A return branch redirects one cycle later to its supplied value without a register write. A source index of 30 sets the enable state to old bit 1 in bit 0, and an index of 31 sets it to old bit 2 in bit 0. Any other index leaves the enable state unchanged.
- R7: Requests on the interrupt input set pending bits. A control write to the pending register (select 3) clears each bit written as 1 and keeps each bit written as 0. A request wins over a clear of the same bit in the same cycle.
- R8: Control writes with select 0 (enable, low 3 bits), 1 (exception base) and 2 (debug base) replace the whole register value one cycle later.
- R9: For the enable state an accepted event outranks a return, which outranks a control write to the enable register. A return in the same cycle as an event is dropped. Base and pending writes in an event cycle still take effect, and that event's vector uses the base value held before the write.
- R10: In a cycle with no event strobe and no return, the next cycle shows no redirect and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | XLEN | Address of the instruction raising an event |
| ev_brk | input | 1 | Breakpoint strobe |
| ev_dbus | input | 1 | Data bus error strobe |
| ev_div0 | input | 1 | Divide-by-zero strobe |
| ev_sys | input | 1 | System call strobe |
| ret_valid | input | 1 | Return branch strobe |
| ret_src | input | 5 | Source register index of the return branch |
| ret_value | input | XLEN | Value of the source register (branch target) |
| csr_we | input | 1 | Control register write strobe |
| csr_sel | input | 2 | Register select: 0 enable, 1 exception base, 2 debug base, 3 pending |
| csr_wdata | input | XLEN | Control write data |
| irq_in | input | PEND_W | Interrupt requests that set pending bits |
| redir_valid | output | 1 | Redirect pulse |
| redir_pc | output | XLEN | Redirect target |
| rf_we | output | 1 | Link register write enable |
| rf_idx | output | 5 | Link register index (30 or 31) |
| rf_data | output | XLEN | Saved address |
| ie_o | output | 3 | Interrupt-enable state |
| eba_o | output | XLEN | Exception base |
| deba_o | output | XLEN | Debug base |
| pend_o | output | PEND_W | Pending register |

## Verification
Every result of this block is due exactly one clock edge after the cycle that carries its stimulus. This holds for the redirect, the link write, the enable update and the control register values. The driver applies stimulus just after a falling edge and pushes the expected item into a queue at the same time. The monitor pops that item at the next falling edge, which is the first one after the capturing rising edge, and compares it there. The monitor also flags any redirect that appears while the queue is empty. Register values are read back at that same falling edge.

// File: rtl/exc_ctrl.sv
`timescale 1ns/1ps
module exc_ctrl #(
  parameter int XLEN      = 32,
  parameter int PEND_W    = 32,
  parameter int VEC_SHIFT = 5,
  parameter int ID_BRK    = 1,
  parameter int ID_DBUS   = 4,
  parameter int ID_DIV0   = 5,
  parameter int ID_SYS    = 7,
  parameter int EXC_LINK  = 30,
  parameter int BRK_LINK  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              ev_brk,
  input  logic              ev_dbus,
  input  logic              ev_div0,
  input  logic              ev_sys,
  input  logic              ret_valid,
  input  logic [4:0]        ret_src,
  input  logic [XLEN-1:0]   ret_value,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic [PEND_W-1:0] irq_in,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc,
  output logic              rf_we,
  output logic [4:0]        rf_idx,
  output logic [XLEN-1:0]   rf_data,
  output logic [2:0]        ie_o,
  output logic [XLEN-1:0]   eba_o,
  output logic [XLEN-1:0]   deba_o,
  output logic [PEND_W-1:0] pend_o
);

  localparam logic [1:0] SEL_IE   = 2'd0;
  localparam logic [1:0] SEL_EBA  = 2'd1;
  localparam logic [1:0] SEL_DEBA = 2'd2;
  localparam logic [1:0] SEL_PEND = 2'd3;
  localparam logic [4:0] XLINK = 5'(EXC_LINK);
  localparam logic [4:0] BLINK = 5'(BRK_LINK);

  logic            exc_any, take;
  logic [2:0]      ev_id;
  logic [XLEN-1:0] base, vec;
  logic [2:0]      ie_nxt;
  logic [PEND_W-1:0] clr_mask;

  assign exc_any = ev_dbus | ev_div0 | ev_sys;
  assign take    = ev_brk | exc_any;

  always_comb begin
    if (ev_brk)       ev_id = 3'(ID_BRK);
    else if (ev_dbus) ev_id = 3'(ID_DBUS);
    else if (ev_div0) ev_id = 3'(ID_DIV0);
    else              ev_id = 3'(ID_SYS);
  end

  assign base = ev_brk ? deba_o : eba_o;
  assign vec  = base + (XLEN'(ev_id) << VEC_SHIFT);

  always_comb begin
    ie_nxt = ie_o;
    if (take)
      ie_nxt = ev_brk ? {ie_o[0], 2'b00} : {1'b0, ie_o[0], 1'b0};
    else if (ret_valid) begin
      if (ret_src == XLINK)      ie_nxt = {2'b00, ie_o[1]};
      else if (ret_src == BLINK) ie_nxt = {2'b00, ie_o[2]};
    end else if (csr_we && csr_sel == SEL_IE)
      ie_nxt = csr_wdata[2:0];
  end

  assign clr_mask = (csr_we && csr_sel == SEL_PEND) ? csr_wdata[PEND_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      rf_we       <= 1'b0;
      rf_idx      <= '0;
      rf_data     <= '0;
      ie_o        <= '0;
      eba_o       <= '0;
      deba_o      <= '0;
      pend_o      <= '0;
    end else begin
      redir_valid <= take | ret_valid;
      redir_pc    <= take ? vec : ret_value;
      rf_we       <= take;
      rf_idx      <= ev_brk ? BLINK : XLINK;
      rf_data     <= pc_i;
      ie_o        <= ie_nxt;
      pend_o      <= (pend_o & ~clr_mask) | irq_in;
      if (csr_we && csr_sel == SEL_EBA)  eba_o  <= csr_wdata;
      if (csr_we && csr_sel == SEL_DEBA) deba_o <= csr_wdata;
    end
  end

endmodule

// File: rtl/exc_ctrl_chk.sv
`timescale 1ns/1ps
module exc_ctrl_chk #(
  parameter int XLEN      = 32,
  parameter int PEND_W    = 32,
  parameter int VEC_SHIFT = 5,
  parameter int ID_BRK    = 1,
  parameter int ID_DIV0   = 5,
  parameter int EXC_LINK  = 30,
  parameter int BRK_LINK  = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   pc_i,
  input logic              ev_brk,
  input logic              ev_dbus,
  input logic              ev_div0,
  input logic              ev_sys,
  input logic              ret_valid,
  input logic [4:0]        ret_src,
  input logic              csr_we,
  input logic [1:0]        csr_sel,
  input logic [XLEN-1:0]   csr_wdata,
  input logic [PEND_W-1:0] irq_in,
  input logic              redir_valid,
  input logic [XLEN-1:0]   redir_pc,
  input logic              rf_we,
  input logic [4:0]        rf_idx,
  input logic [XLEN-1:0]   rf_data,
  input logic [2:0]        ie_o,
  input logic [XLEN-1:0]   eba_o,
  input logic [XLEN-1:0]   deba_o,
  input logic [PEND_W-1:0] pend_o
);

  assert_div0_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_div0 && !ev_brk && !ev_dbus) |=> (redir_valid && rf_we &&
      rf_idx == 5'(EXC_LINK) && rf_data == $past(pc_i) &&
      redir_pc == $past(eba_o) + XLEN'(ID_DIV0 << VEC_SHIFT)));

  assert_ie_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_brk && (ev_dbus || ev_div0 || ev_sys)) |=> ie_o == {1'b0, $past(ie_o[0]), 1'b0});

  assert_brk_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_brk |=> (rf_idx == 5'(BRK_LINK) && ie_o == {$past(ie_o[0]), 2'b00} &&
      redir_pc == $past(deba_o) + XLEN'(ID_BRK << VEC_SHIFT)));

  assert_ret_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ev_brk && !ev_dbus && !ev_div0 && !ev_sys && ret_src == 5'(EXC_LINK))
      |=> (ie_o == {2'b00, $past(ie_o[1])} && redir_valid && !rf_we));

  assert_pend_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_sel == 2'd3 && irq_in == '0)
      |=> pend_o == ($past(pend_o) & ~$past(csr_wdata[PEND_W-1:0])));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_brk && !ev_dbus && !ev_div0 && !ev_sys && !ret_valid) |=> (!redir_valid && !rf_we));

endmodule

bind exc_ctrl exc_ctrl_chk #(
  .XLEN(XLEN), .PEND_W(PEND_W), .VEC_SHIFT(VEC_SHIFT), .ID_BRK(ID_BRK),
  .ID_DIV0(ID_DIV0), .EXC_LINK(EXC_LINK), .BRK_LINK(BRK_LINK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .ev_brk(ev_brk), .ev_dbus(ev_dbus),
  .ev_div0(ev_div0), .ev_sys(ev_sys), .ret_valid(ret_valid), .ret_src(ret_src),
  .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata), .irq_in(irq_in),
  .redir_valid(redir_valid), .redir_pc(redir_pc), .rf_we(rf_we), .rf_idx(rf_idx),
  .rf_data(rf_data), .ie_o(ie_o), .eba_o(eba_o), .deba_o(deba_o), .pend_o(pend_o)
);

// File: tb/exc_ctrl_test.sv
`timescale 1ns/1ps
module exc_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [31:0] pc_i = 0, ret_value = 0, csr_wdata = 0, irq_in = 0;
  logic ev_brk = 0, ev_dbus = 0, ev_div0 = 0, ev_sys = 0, ret_valid = 0, csr_we = 0;
  logic [4:0] ret_src = 0;
  logic [1:0] csr_sel = 0;
  logic redir_valid, rf_we;
  logic [31:0] redir_pc, rf_data, eba_o, deba_o, pend_o;
  logic [4:0] rf_idx;
  logic [2:0] ie_o;

  int tests = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [31:0] pc; logic we; logic [4:0] idx; logic [31:0] data; logic [2:0] ie; string tag; } exp_t;
  exp_t q[$];

  logic [2:0]  m_ie = 0;
  logic [31:0] m_eba = 0, m_deba = 0, m_pend = 0;

  always #2.5 clk = ~clk;

  exc_ctrl uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " redirect"}, {31'd0, redir_valid}, 32'd1);
        chk({e.tag, " target"}, redir_pc, e.pc);
        chk({e.tag, " rf_we"}, {31'd0, rf_we}, {31'd0, e.we});
        if (e.we) begin
          chk({e.tag, " rf_idx"}, {27'd0, rf_idx}, {27'd0, e.idx});
          chk({e.tag, " rf_data"}, rf_data, e.data);
        end
        chk({e.tag, " ie"}, {29'd0, ie_o}, {29'd0, e.ie});
      end else if (redir_valid || rf_we) begin
        tests++; fails++;
        $display("FAIL R10 unexpected redirect actual=%b expected=0", redir_valid);
      end
    end
  end

  // One stimulus cycle; the model derives the expected results.
  task automatic step(input string tag, input logic [3:0] ev, input logic [31:0] pc,
                      input logic rv, input logic [4:0] rs, input logic [31:0] rval,
                      input logic cw, input logic [1:0] cs, input logic [31:0] cd,
                      input logic [31:0] irq);
    exp_t e;
    logic [2:0] id;
    @(negedge clk); #1;
    {ev_brk, ev_dbus, ev_div0, ev_sys} = ev;
    pc_i = pc; ret_valid = rv; ret_src = rs; ret_value = rval;
    csr_we = cw; csr_sel = cs; csr_wdata = cd; irq_in = irq;
    e.tag = tag; e.we = 0; e.idx = 0; e.data = 0;
    if (ev != 0) begin
      id = ev[3] ? 3'd1 : ev[2] ? 3'd4 : ev[1] ? 3'd5 : 3'd7;
      e.pc = (ev[3] ? m_deba : m_eba) + 32'(id) * 32;
      e.we = 1; e.idx = ev[3] ? 5'd31 : 5'd30; e.data = pc;
      m_ie = ev[3] ? {m_ie[0], 2'b00} : {1'b0, m_ie[0], 1'b0};
    end else if (rv) begin
      e.pc = rval;
      if (rs == 30) m_ie = {2'b00, m_ie[1]};
      else if (rs == 31) m_ie = {2'b00, m_ie[2]};
    end else if (cw && cs == 0) m_ie = cd[2:0];
    if (cw && cs == 1) m_eba = cd;
    if (cw && cs == 2) m_deba = cd;
    m_pend = (m_pend & ~((cw && cs == 3) ? cd : 32'd0)) | irq;
    e.ie = m_ie;
    if (ev != 0 || rv) q.push_back(e);
    @(negedge clk); #1;
    {ev_brk, ev_dbus, ev_div0, ev_sys} = 0;
    ret_valid = 0; csr_we = 0; irq_in = 0;
  endtask

  task automatic ev_only(input string tag, input logic [3:0] ev, input logic [31:0] pc);
    step(tag, ev, pc, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic ret_only(input string tag, input logic [4:0] rs, input logic [31:0] v);
    step(tag, 0, 0, 1, rs, v, 0, 0, 0, 0);
  endtask
  task automatic csr(input string tag, input logic [1:0] s, input logic [31:0] d);
    step(tag, 0, 0, 0, 0, 0, 1, s, d, 0);
  endtask

  task automatic regs(input string tag);
    chk({tag, " ie"}, {29'd0, ie_o}, {29'd0, m_ie});
    chk({tag, " eba"}, eba_o, m_eba);
    chk({tag, " deba"}, deba_o, m_deba);
    chk({tag, " pend"}, pend_o, m_pend);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    regs("R1");
    chk("R1 redirect", {31'd0, redir_valid}, 0);
    chk("R1 rf_we", {31'd0, rf_we}, 0);
    #1 rst_n = 1;

    csr("R8 eba", 1, 32'h0000_1000);
    csr("R8 deba", 2, 32'h0000_2000);
    csr("R8 ie", 0, 32'hFFFF_FFF9);
    regs("R8");

    ev_only("R2 R3 div0", 4'b0010, 32'h100);
    ret_only("R6 ret30", 30, 32'h104);
    ev_only("R2 R3 sys", 4'b0001, 32'h200);
    ret_only("R6 ret30 b", 30, 32'h204);
    ev_only("R2 R3 dbus", 4'b0100, 32'h280);
    ret_only("R6 ret30 c", 30, 32'h284);
    ev_only("R4 brk", 4'b1000, 32'h300);
    ret_only("R6 ret31", 31, 32'h304);
    ret_only("R6 ret other", 5, 32'h40);
    csr("R8 ie2", 0, 32'h6);
    ev_only("R4 brk ie0=0", 4'b1000, 32'h310);
    ret_only("R6 ret31 b", 31, 32'h314);
    regs("R6");

    csr("R8 ie3", 0, 32'h1);
    ev_only("R5 all four", 4'b1111, 32'h400);
    ret_only("R6 ret31 c", 31, 32'h404);
    ev_only("R5 dbus>div0>sys", 4'b0111, 32'h410);
    ev_only("R5 div0>sys", 4'b0011, 32'h420);

    csr("R8 ie4", 0, 32'h1);
    step("R9 ev+ret+eba", 4'b0001, 32'h500, 1, 30, 32'h999, 1, 1, 32'h8000, 0);
    regs("R9");
    step("R9 ev+iewr", 4'b0010, 32'h510, 0, 0, 0, 1, 0, 32'h7, 0);
    step("R9 ret+iewr", 0, 0, 1, 30, 32'h520, 1, 0, 32'h4, 0);
    regs("R9 b");

    step("R7 irq", 0, 0, 0, 0, 0, 0, 0, 0, 32'hF0F0);
    regs("R7 set");
    csr("R7 w1c", 3, 32'h0000_00F0);
    regs("R7 clr");
    csr("R7 w0", 3, 32'h0);
    regs("R7 keep");
    step("R7 set wins", 0, 0, 0, 0, 0, 1, 3, 32'h0000_1001, 32'h0000_0001);
    regs("R7 race");

    repeat (3) @(negedge clk);
    chk("R10 idle", {31'd0, redir_valid}, 0);
    chk("R10 queue drained", q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    done = 1;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule